// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block places each accepted Ethernet frame into a circular buffer held in local byte memory. The buffer is divided into 256-byte pages. A start page and a stop page bound it, and the stop page is the first page that lies outside the ring. Software reports how far it has read with a boundary page. The block keeps a current page that marks where the next frame will go.

Frame bytes arrive one per clock on a valid/ready stream, with a last marker on the final byte. When the first byte of a frame arrives, the block decides whether to keep or discard the frame. It discards the frame when the stop command is set or when the ring lacks room for a maximum-size frame. A kept frame is written from offset 4 of the current page onward, and the write address wraps from the stop page back to the start page. Frames shorter than the minimum are padded with zero bytes.

Once the length is known, the block writes a 4-byte link header into the first bytes of the current page. It then advances the current page to the precomputed next page and pulses a receive interrupt. Software may load the current page directly while the writer is idle.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, cur_pg is 0, rx_ready is 1, mem_we is 0 and rx_irq is 0.
- R2: A frame whose first byte is taken while cmd_stop is 1 is discarded. It causes no memory write and no rx_irq, and cur_pg does not change.
- R3: Free space is computed in bytes. Let C = cur_pg*256 and B = bound_pg*256. The free space is B-C when C<B, and (stop_pg-start_pg)*256-(C-B) otherwise. A frame is discarded as in R2 when this value is below 1518. A value of exactly 1536 (six pages) accepts the frame.
- R4: Frame byte k is written to address cur_pg*256+4+k. An address that reaches stop_pg*256 continues at start_pg*256. No write falls outside the ring.
- R5: A frame shorter than 60 bytes is extended to 60 bytes with zero bytes. The stored length L is the padded size plus 4.
- R6: The header occupies addresses cur_pg*256+0..3 and holds, in order: the status byte, the next page, L[7:0] and L[15:8]. In the status byte, bit 0 is 1 and bit 5 copies bit 0 of the first frame byte. All other status bits are 0.
- R7: The next page is cur_pg + ceil((L+4)/256). When that is at or above stop_pg, (stop_pg-start_pg) is subtracted from it.
- R8: After the header is written, cur_pg takes the next page value and rx_irq is high for exactly one cycle. This happens once per stored frame.
- R9: A cur_load pulse while idle sets cur_pg to cur_load_pg. rx_ready is 0 during that cycle.
- R10: rx_ready is 0 while padding and header bytes are being written. This state follows the last frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Block can take a byte this cycle |
| cmd_stop | input | 1 | Stop command; discards frames |
| start_pg | input | PAGE_W | First page of the ring |
| stop_pg | input | PAGE_W | Page just past the ring |
| bound_pg | input | PAGE_W | Software read boundary page |
| cur_load | input | 1 | Load strobe for the current page |
| cur_load_pg | input | PAGE_W | Value loaded into the current page |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | PAGE_W+OFF_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| rx_irq | output | 1 | One-cycle pulse when a frame has been stored |
| cur_pg | output | PAGE_W | Current page |

## Verification
A wrong write pointer or a missed wrap shows up at the memory port while the frame is still arriving. It appears as data bytes landing at the wrong address, or as a write outside the ring. A wrong byte counter or a wrong next-page calculation is hidden until the header is written, a few cycles after the last byte. At that point it shows as a wrong length or link byte, and on the same edge as a wrong cur_pg. A wrong free-space decision shows only as a frame that is stored or discarded against expectation. It is detected within about forty cycles after the last byte, by counting writes and interrupts.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_DATA = 3'd1,
      S_DROP = 3'd2,
      S_PAD  = 3'd3,
      S_HDR  = 3'd4
   } rbw_state_e;

   localparam int unsigned HDR_BYTES = 4;
   localparam int unsigned STAT_OK_BIT = 0;
   localparam int unsigned STAT_GRP_BIT = 5;
endpackage

// File: rtl/rbw_space_chk.sv
module rbw_space_chk #(
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned NEED_BYTES = 1518
) (
   input  logic [PAGE_W-1:0] cur_pg,
   input  logic [PAGE_W-1:0] bound_pg,
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   output logic              room_ok
);
   localparam int unsigned AW1 = PAGE_W + OFF_W + 1;
   localparam logic [AW1-1:0] NEED = AW1'(NEED_BYTES);

   logic [PAGE_W:0] ring_pg;
   logic [AW1-1:0]  ring_b, idx_b, bnd_b, free_b;

   always_comb begin
      ring_pg = {1'b0, stop_pg} - {1'b0, start_pg};
      ring_b  = {ring_pg, {OFF_W{1'b0}}};
      idx_b   = {1'b0, cur_pg, {OFF_W{1'b0}}};
      bnd_b   = {1'b0, bound_pg, {OFF_W{1'b0}}};
      if (idx_b < bnd_b) free_b = bnd_b - idx_b;
      else               free_b = ring_b - (idx_b - bnd_b);
      room_ok = (free_b >= NEED);
   end
endmodule

// File: rtl/rbw_next_page.sv
module rbw_next_page #(
   parameter int unsigned PAGE_W = 8,
   parameter int unsigned OFF_W  = 8,
   parameter int unsigned LEN_W  = 16
) (
   input  logic [PAGE_W-1:0] cur_pg,
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   input  logic [LEN_W-1:0]  stored_len,
   output logic [PAGE_W-1:0] next_pg
);
   localparam int unsigned SW = LEN_W + PAGE_W + 2;
   localparam logic [SW-1:0] ROUND = SW'(4 + (1 << OFF_W) - 1);

   logic [SW-1:0] span, sum, stop_x, ring_x;

   always_comb begin
      span   = (SW'(stored_len) + ROUND) >> OFF_W;
      sum    = SW'(cur_pg) + span;
      stop_x = SW'(stop_pg);
      ring_x = SW'(stop_pg) - SW'(start_pg);
      if (sum >= stop_x) sum = sum - ring_x;
      next_pg = sum[PAGE_W-1:0];
   end
endmodule

// File: rtl/rbw_wr_ptr.sv
module rbw_wr_ptr #(
   parameter int unsigned PAGE_W = 8,
   parameter int unsigned OFF_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [PAGE_W+OFF_W-1:0]  load_addr,
   input  logic                     adv,
   input  logic [PAGE_W-1:0]        start_pg,
   input  logic [PAGE_W-1:0]        stop_pg,
   output logic [PAGE_W+OFF_W-1:0]  ptr
);
   localparam int unsigned AW = PAGE_W + OFF_W;

   logic [AW-1:0] start_a, last_a;

   assign start_a = {start_pg, {OFF_W{1'b0}}};
   assign last_a  = {stop_pg, {OFF_W{1'b0}}} - AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr <= '0;
      else if (load)       ptr <= load_addr;
      else if (adv) begin
         if (ptr == last_a) ptr <= start_a;
         else               ptr <= ptr + AW'(1);
      end
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rbw_pkg::*;
#(
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned MAX_FRAME = 1514,
   parameter int unsigned MIN_FRAME = 60,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_valid,
   input  logic [7:0]               rx_data,
   input  logic                     rx_last,
   output logic                     rx_ready,
   input  logic                     cmd_stop,
   input  logic [PAGE_W-1:0]        start_pg,
   input  logic [PAGE_W-1:0]        stop_pg,
   input  logic [PAGE_W-1:0]        bound_pg,
   input  logic                     cur_load,
   input  logic [PAGE_W-1:0]        cur_load_pg,
   output logic                     mem_we,
   output logic [PAGE_W+OFF_W-1:0]  mem_addr,
   output logic [7:0]               mem_wdata,
   output logic                     rx_irq,
   output logic [PAGE_W-1:0]        cur_pg
);
   localparam int unsigned AW = PAGE_W + OFF_W;
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
   localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);

   if (OFF_W < 3) begin : g_bad_off
      $error("OFF_W must allow the header and first byte in one page");
   end
   if (LEN_W < 11 || LEN_W > 16) begin : g_bad_len
      $error("LEN_W must hold a maximum frame and fit two header bytes");
   end
   if (MAX_FRAME + HDR_BYTES >= (1 << (AW + 1))) begin : g_bad_max
      $error("MAX_FRAME too large for the address space");
   end

   rbw_state_e        state_q, state_d;
   logic [PAGE_W-1:0] cur_q, cur_d;
   logic [LEN_W-1:0]  cnt_q, cnt_d;
   logic              grp_q, grp_d;
   logic [1:0]        hidx_q, hidx_d;

   logic              take, room_ok, accept;
   logic [AW-1:0]     base_a, base4_a, ptr;
   logic              ptr_load, ptr_adv;
   logic [LEN_W-1:0]  stored_len;
   logic [15:0]       len16;
   logic [PAGE_W-1:0] next_pg;
   logic [7:0]        status_b;

   logic              wr_en, irq_c;
   logic [AW-1:0]     wr_addr;
   logic [7:0]        wr_data;

   rbw_space_chk #(
      .PAGE_W(PAGE_W), .OFF_W(OFF_W), .NEED_BYTES(MAX_FRAME + HDR_BYTES)
   ) u_space (
      .cur_pg(cur_q), .bound_pg(bound_pg), .start_pg(start_pg),
      .stop_pg(stop_pg), .room_ok(room_ok)
   );

   rbw_next_page #(
      .PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
   ) u_next (
      .cur_pg(cur_q), .start_pg(start_pg), .stop_pg(stop_pg),
      .stored_len(stored_len), .next_pg(next_pg)
   );

   rbw_wr_ptr #(
      .PAGE_W(PAGE_W), .OFF_W(OFF_W)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_addr(base4_a + AW'(1)),
      .adv(ptr_adv), .start_pg(start_pg), .stop_pg(stop_pg), .ptr(ptr)
   );

   assign rx_ready = ((state_q == S_IDLE) && !cur_load) ||
                     (state_q == S_DATA) || (state_q == S_DROP);
   assign take     = rx_valid && rx_ready;
   assign accept   = !cmd_stop && room_ok;
   assign base_a   = {cur_q, {OFF_W{1'b0}}};
   assign base4_a  = base_a + AW'(HDR_BYTES);
   assign stored_len = cnt_q + HDR_L;
   assign len16    = 16'(stored_len);
   assign cur_pg   = cur_q;

   always_comb begin
      status_b = '0;
      status_b[STAT_OK_BIT]  = 1'b1;
      status_b[STAT_GRP_BIT] = grp_q;
   end

   always_comb begin
      wr_en    = 1'b0;
      wr_addr  = ptr;
      wr_data  = rx_data;
      ptr_load = 1'b0;
      ptr_adv  = 1'b0;
      irq_c    = 1'b0;
      state_d  = state_q;
      cnt_d    = cnt_q;
      grp_d    = grp_q;
      hidx_d   = hidx_q;
      cur_d    = cur_q;
      case (state_q)
         S_IDLE: begin
            hidx_d = 2'd0;
            if (cur_load) begin
               cur_d = cur_load_pg;
            end else if (take) begin
               if (accept) begin
                  wr_en    = 1'b1;
                  wr_addr  = base4_a;
                  ptr_load = 1'b1;
                  cnt_d    = LEN_W'(1);
                  grp_d    = rx_data[0];
                  if (rx_last) state_d = (LEN_W'(1) < MIN_L) ? S_PAD : S_HDR;
                  else         state_d = S_DATA;
               end else if (!rx_last) begin
                  state_d = S_DROP;
               end
            end
         end
         S_DATA: begin
            if (take) begin
               wr_en   = 1'b1;
               ptr_adv = 1'b1;
               cnt_d   = cnt_q + LEN_W'(1);
               if (rx_last) state_d = (cnt_q + LEN_W'(1) < MIN_L) ? S_PAD : S_HDR;
            end
         end
         S_DROP: begin
            if (take && rx_last) state_d = S_IDLE;
         end
         S_PAD: begin
            wr_en   = 1'b1;
            wr_data = 8'h00;
            ptr_adv = 1'b1;
            cnt_d   = cnt_q + LEN_W'(1);
            if (cnt_q + LEN_W'(1) >= MIN_L) state_d = S_HDR;
         end
         S_HDR: begin
            wr_en   = 1'b1;
            wr_addr = base_a + AW'(hidx_q);
            case (hidx_q)
               2'd0:    wr_data = status_b;
               2'd1:    wr_data = 8'(next_pg);
               2'd2:    wr_data = len16[7:0];
               default: wr_data = len16[15:8];
            endcase
            hidx_d = hidx_q + 2'd1;
            if (hidx_q == 2'd3) begin
               irq_c   = 1'b1;
               cur_d   = next_pg;
               state_d = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cur_q   <= '0;
         cnt_q   <= '0;
         grp_q   <= 1'b0;
         hidx_q  <= 2'd0;
      end else begin
         state_q <= state_d;
         cur_q   <= cur_d;
         cnt_q   <= cnt_d;
         grp_q   <= grp_d;
         hidx_q  <= hidx_d;
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rx_irq    <= 1'b0;
         end else begin
            mem_we    <= wr_en;
            mem_addr  <= wr_addr;
            mem_wdata <= wr_data;
            rx_irq    <= irq_c;
         end
      end
   end else begin : g_comb_out
      assign mem_we    = wr_en;
      assign mem_addr  = wr_addr;
      assign mem_wdata = wr_data;
      assign rx_irq    = irq_c;
   end

   // R8: the interrupt is a single-cycle pulse
   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   // R8, R9: the current page moves only on frame completion or a load
   p_cur_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_pg) |-> (rx_irq || $past(rx_irq) || $past(cur_load)));

   // R4: every write lands inside the ring
   p_addr_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr >= {start_pg, {OFF_W{1'b0}}} &&
                  mem_addr <  {stop_pg,  {OFF_W{1'b0}}}));

   // R5: header phase only after the count has reached the minimum
   p_len_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_HDR) |-> (cnt_q >= MIN_L));

   // R7: the link page stays inside the ring
   p_next_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_HDR) |-> (next_pg >= start_pg && next_pg < stop_pg));

   // R2: a discarded frame produces no writes
   p_drop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DROP) |-> !wr_en);
endmodule

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
   localparam int RING_LO = 'h40;
   localparam int RING_HI = 'h50;
   localparam int RING_B  = (RING_HI - RING_LO) * 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_last = 1'b0;
   logic       rx_ready;
   logic       cmd_stop = 1'b0;
   logic [7:0] start_pg = 8'h00, stop_pg = 8'h00, bound_pg = 8'h00;
   logic       cur_load = 1'b0;
   logic [7:0] cur_load_pg = 8'h00;
   logic       mem_we;
   logic [15:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       rx_irq;
   logic [7:0] cur_pg;

   int n_chk = 0, n_fail = 0;
   int wr_cnt = 0, irq_cnt = 0, out_cnt = 0;
   logic [7:0] bmem [0:RING_B-1];
   logic [7:0] frm  [0:1513];

   always #2.5 clk = ~clk;

   rx_ring_writer u_rx_ring_writer (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .rx_ready(rx_ready), .cmd_stop(cmd_stop),
      .start_pg(start_pg), .stop_pg(stop_pg), .bound_pg(bound_pg),
      .cur_load(cur_load), .cur_load_pg(cur_load_pg), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_irq(rx_irq),
      .cur_pg(cur_pg)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_irq) irq_cnt++;
         if (mem_we) begin
            wr_cnt++;
            if (int'(mem_addr) >= RING_LO*256 && int'(mem_addr) < RING_HI*256)
               bmem[int'(mem_addr) - RING_LO*256] = mem_wdata;
            else out_cnt++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_next(input int cur, input int stored);
      int n;
      n = cur + (stored + 4 + 255) / 256;
      if (n >= RING_HI) n = n - (RING_HI - RING_LO);
      return n;
   endfunction

   function automatic int ofs(input int a);
      int x;
      x = a;
      if (x >= RING_HI*256) x = x - RING_B;
      return x - RING_LO*256;
   endfunction

   task automatic send_frame(input int len, input bit grp);
      for (int k = 0; k < len; k++) frm[k] = 8'($urandom);
      frm[0][0] = grp;
      for (int k = 0; k < len; k++) begin
         if ($urandom % 8 == 0) begin
            rx_valid = 1'b0;
            @(negedge clk);
         end
         while (!rx_ready) @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = frm[k];
         rx_last  = (k == len - 1);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
   endtask

   task automatic run_good(input int len, input bit grp);
      int c0, ic, plen, stored, nxt, bad, pbad, t;
      logic [7:0] st;
      c0 = int'(cur_pg);
      ic = irq_cnt;
      send_frame(len, grp);
      check(rx_ready == 1'b0, "R10", "ready after last byte", int'(rx_ready), 0);
      t = 0;
      while (irq_cnt == ic && t < 200) begin
         @(negedge clk);
         t++;
      end
      plen   = (len < 60) ? 60 : len;
      stored = plen + 4;
      nxt    = exp_next(c0, stored);
      st     = 8'h01 | (grp ? 8'h20 : 8'h00);
      check(bmem[ofs(c0*256)] == st, "R6", "status byte", int'(bmem[ofs(c0*256)]), int'(st));
      check(bmem[ofs(c0*256+1)] == 8'(nxt), "R6", "link byte", int'(bmem[ofs(c0*256+1)]), nxt);
      check({bmem[ofs(c0*256+3)], bmem[ofs(c0*256+2)]} == 16'(stored), "R5",
            "stored length", int'({bmem[ofs(c0*256+3)], bmem[ofs(c0*256+2)]}), stored);
      bad = 0;
      pbad = 0;
      for (int k = 0; k < plen; k++) begin
         if (k < len) begin
            if (bmem[ofs(c0*256 + 4 + k)] != frm[k]) bad++;
         end else begin
            if (bmem[ofs(c0*256 + 4 + k)] != 8'h00) pbad++;
         end
      end
      check(bad == 0, "R4", "data byte mismatches", bad, 0);
      check(pbad == 0, "R5", "nonzero pad bytes", pbad, 0);
      check(int'(cur_pg) == nxt, "R7", "current page after frame", int'(cur_pg), nxt);
      repeat (3) @(negedge clk);
      check(irq_cnt == ic + 1, "R8", "interrupt count", irq_cnt, ic + 1);
      bound_pg = cur_pg;
   endtask

   task automatic run_drop(input int len, input string req);
      int c0, ic, wc;
      c0 = int'(cur_pg);
      ic = irq_cnt;
      wc = wr_cnt;
      send_frame(len, 1'b0);
      repeat (40) @(negedge clk);
      check(wr_cnt == wc, req, "writes of dropped frame", wr_cnt - wc, 0);
      check(irq_cnt == ic, req, "interrupt of dropped frame", irq_cnt - ic, 0);
      check(int'(cur_pg) == c0, req, "page after dropped frame", int'(cur_pg), c0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cur_pg == 8'h00, "R1", "cur_pg at reset", int'(cur_pg), 0);
      check(rx_ready == 1'b1, "R1", "rx_ready at reset", int'(rx_ready), 1);
      check(mem_we == 1'b0, "R1", "mem_we at reset", int'(mem_we), 0);
      check(rx_irq == 1'b0, "R1", "rx_irq at reset", int'(rx_irq), 0);

      start_pg = 8'(RING_LO);
      stop_pg  = 8'(RING_HI);
      bound_pg = 8'(RING_LO);
      // R9 current page load
      cur_load = 1'b1;
      cur_load_pg = 8'(RING_LO);
      #1;
      check(rx_ready == 1'b0, "R9", "ready during load", int'(rx_ready), 0);
      @(negedge clk);
      cur_load = 1'b0;
      check(int'(cur_pg) == RING_LO, "R9", "loaded page", int'(cur_pg), RING_LO);

      run_good(100, 1'b0);
      run_good(20, 1'b1);
      run_good(1, 1'b0);
      run_good(60, 1'b1);
      run_good(59, 1'b0);
      run_good(252, 1'b0);
      run_good(1514, 1'b1);

      for (int i = 0; i < 10; i++) run_good(1 + int'($urandom % 1514), 1'($urandom));

      // R2 stop command discards
      cmd_stop = 1'b1;
      run_drop(80, "R2");
      cmd_stop = 1'b0;

      // R3 free space of five pages is too little, six is enough
      bound_pg = 8'(RING_LO + ((int'(cur_pg) - RING_LO + 5) % 16));
      run_drop(200, "R3");
      bound_pg = 8'(RING_LO + ((int'(cur_pg) - RING_LO + 6) % 16));
      run_good(200, 1'b0);

      // R3 boundary ahead of current page by one page
      bound_pg = 8'(RING_LO + ((int'(cur_pg) - RING_LO + 1) % 16));
      run_drop(64, "R3");
      bound_pg = cur_pg;

      // R4 wrap to near the top and cross the stop page
      cur_load = 1'b1;
      cur_load_pg = 8'(RING_HI - 1);
      @(negedge clk);
      cur_load = 1'b0;
      bound_pg = cur_pg;
      run_good(700, 1'b1);
      run_good(300, 1'b0);

      check(out_cnt == 0, "R4", "writes outside ring", out_cnt, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule